// File: doc/BRIEF.md
# Configurable Up/Down Timer Counter

This block is a timer counter whose width is set by a parameter and defaults to 16 bits. It counts enable ticks from a count clock that is chosen outside the block. A 2-bit direction field selects counting up, counting down, or counting up and then down. A separate one-shot input picks between a single cycle and repeated cycles, which gives six working combinations. A programmable maximum bounds the count to the range from zero up to that maximum. At every cycle boundary a one-cycle pulse is produced, and this pulse can feed an interrupt or DMA request.

Software controls the counter with three single-cycle strobes: preset, start and stop. It can rewrite the maximum at any time. While the counter is stopped, a new maximum takes effect at once. While it runs, the new value is parked and a busy flag is raised. The parked value moves into the active maximum at the next cycle boundary. A write made while the flag is set is dropped.

The sequencer has three states. `ST_STOP` means idle. `ST_RISE` means counting up. `ST_FALL` means counting down. These transitions are named:
- *launch*: `ST_STOP` to `ST_RISE`/`ST_FALL` on start.
- *halt*: any running state to `ST_STOP` on stop.
- *finish*: any running state to `ST_STOP` at a one-shot boundary.
- *reverse*: `ST_RISE` to `ST_FALL` at the top in up/down mode.
- *rebound*: `ST_FALL` to `ST_RISE` at zero in up/down mode.
- *realign*: preset or a direction change while running moves the state to the one the direction asks for.

Top module: `tick_timer`

## Requirements
- R1: After reset the count is 0, running, busy and cycle_done are all low, and the maximum holds all ones. The all-ones maximum can be seen by presetting in down mode.
- R2: The count changes only on a cycle where the counter is running and tick_en is high. While the counter is stopped the count holds its value.
- R3: Up direction (dir_mode 00; 11 acts the same) adds one per tick. On a tick where the count is at or above the maximum, the count wraps to 0 and cycle_done pulses on the same edge.
- R4: Down direction (dir_mode 01) subtracts one per tick. On a tick at 0 the count reloads the maximum and cycle_done pulses.
- R5: Up/down direction (dir_mode 10) runs 0 to maximum and back to 0. Each endpoint is held for one tick. cycle_done pulses as the count leaves 0 for 1.
- R6: With one_shot high, the first cycle boundary makes the count 0, pulses cycle_done and clears running. In down and up/down directions the count stays at 0 rather than reloading.
- R7: Preset loads the maximum in down direction and 0 otherwise. Preset wins over a tick in the same cycle.
- R8: run_start starts a stopped counter. The count does not move on the start edge. run_stop stops it on the next edge and wins over a tick in the same cycle.
- R9: A maximum write while running sets max_busy on the next edge and is applied at the next boundary, where max_busy clears. Writes made while max_busy is high are ignored.
- R10: A maximum write while stopped applies at once and leaves max_busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count-clock enable tick |
| dir_mode | input | 2 | 00 up, 01 down, 10 up/down, 11 up |
| one_shot | input | 1 | 1 stops after one cycle, 0 repeats |
| preset | input | 1 | Strobe: load 0 or the maximum |
| run_start | input | 1 | Strobe: start counting |
| run_stop | input | 1 | Strobe: stop counting |
| max_wr | input | 1 | Maximum write strobe |
| max_data | input | CNT_W | Maximum value to write |
| max_busy | output | 1 | Deferred maximum pending |
| count | output | CNT_W | Current count |
| running | output | 1 | Counter is running |
| cycle_done | output | 1 | One-cycle boundary pulse |

## Verification
A wrong sequencer state shows up at the count within one tick. A stale rise or fall state makes the next value step the wrong way. A wrong stopped state either freezes the count or lets it move while `running` is low. A deferred maximum that is applied early or late moves the next wrap or reload point, and `max_busy` shows the mismatch on the very next edge after the write. Each count test therefore samples every cycle across at least one full period plus the boundary after it.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    typedef enum logic [1:0] {
        DIR_UP     = 2'b00,
        DIR_DOWN   = 2'b01,
        DIR_UPDOWN = 2'b10,
        DIR_UP_ALT = 2'b11
    } dir_mode_e;

    typedef enum logic [1:0] {
        ST_STOP = 2'b00,
        ST_RISE = 2'b01,
        ST_FALL = 2'b10
    } seq_state_e;

    // State a run begins in for a given direction
    function automatic seq_state_e start_state(input dir_mode_e mode);
        return (mode == DIR_DOWN) ? ST_FALL : ST_RISE;
    endfunction

endpackage

// File: rtl/tick_timer_limit.sv
module tick_timer_limit
    import tick_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             boundary,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] max_act,
    output logic [CNT_W-1:0] max_next,
    output logic             busy
);

    localparam logic [CNT_W-1:0] MAX_RESET = '1;

    logic [CNT_W-1:0] act_q;
    logic [CNT_W-1:0] pend_q;
    logic             pend_v_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q    <= MAX_RESET;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
        end else if (!running) begin
            // Stopped: writes apply at once, any leftover pending value lands
            if (wr_en) begin
                act_q <= wr_data;
            end else if (pend_v_q) begin
                act_q <= pend_q;
            end
            pend_v_q <= 1'b0;
        end else if (boundary && pend_v_q) begin
            act_q    <= pend_q;
            pend_v_q <= 1'b0;
        end else if (wr_en && !pend_v_q) begin
            pend_q   <= wr_data;
            pend_v_q <= 1'b1;
        end
    end

    always_comb begin
        max_act  = act_q;
        max_next = pend_v_q ? pend_q : act_q;
        busy     = pend_v_q;
    end

endmodule

// File: rtl/tick_timer_seq.sv
module tick_timer_seq
    import tick_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  dir_mode_e  mode,
    input  logic       one_shot,
    input  logic       run_start,
    input  logic       run_stop,
    input  logic       preset,
    input  logic       advance,
    input  logic       at_top,
    input  logic       at_end,
    output seq_state_e state,
    output logic       running
);

    seq_state_e st_q;
    seq_state_e st_d;

    // Next-state selection
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_STOP: begin
                if (run_start && !run_stop) begin
                    st_d = start_state(mode);           // launch
                end
            end
            ST_RISE, ST_FALL: begin
                if (run_stop) begin
                    st_d = ST_STOP;                     // halt
                end else if (preset) begin
                    st_d = start_state(mode);           // realign
                end else if (advance) begin
                    if (at_end && one_shot) begin
                        st_d = ST_STOP;                 // finish
                    end else begin
                        unique case (mode)
                            DIR_UPDOWN: begin
                                if (st_q == ST_RISE && at_top) begin
                                    st_d = ST_FALL;     // reverse
                                end else if (st_q == ST_FALL && at_end) begin
                                    st_d = ST_RISE;     // rebound
                                end
                            end
                            DIR_DOWN:          st_d = ST_FALL;
                            DIR_UP, DIR_UP_ALT: st_d = ST_RISE;
                            default:           st_d = ST_RISE;
                        endcase
                    end
                end
            end
            default: st_d = ST_STOP;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_STOP;
        end else begin
            st_q <= st_d;
        end
    end

    // Outputs
    always_comb begin
        state   = st_q;
        running = (st_q != ST_STOP);
    end

endmodule

// File: rtl/tick_timer_count.sv
module tick_timer_count
    import tick_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dir_mode_e        mode,
    input  seq_state_e       state,
    input  logic             one_shot,
    input  logic             preset,
    input  logic             advance,
    input  logic [CNT_W-1:0] max_act,
    input  logic [CNT_W-1:0] max_next,
    output logic [CNT_W-1:0] count,
    output logic             at_top,
    output logic             at_end,
    output logic             cycle_done
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             done_q;
    logic             hit_max;
    logic             hit_zero;

    assign hit_max  = (cnt_q >= max_act);
    assign hit_zero = (cnt_q == CNT_ZERO);

    // Boundary detection per direction
    always_comb begin
        at_top = 1'b0;
        at_end = 1'b0;
        unique case (mode)
            DIR_DOWN:   at_end = hit_zero;
            DIR_UPDOWN: begin
                at_top = (state == ST_RISE) && hit_max;
                at_end = (state == ST_FALL) && hit_zero;
            end
            DIR_UP, DIR_UP_ALT: at_end = hit_max;
            default:    at_end = hit_max;
        endcase
    end

    // Next count
    always_comb begin
        cnt_d = cnt_q;
        if (preset) begin
            cnt_d = (mode == DIR_DOWN) ? max_act : CNT_ZERO;
        end else if (advance) begin
            unique case (mode)
                DIR_DOWN: begin
                    if (at_end) begin
                        cnt_d = one_shot ? CNT_ZERO : max_next;
                    end else begin
                        cnt_d = cnt_q - CNT_ONE;
                    end
                end
                DIR_UPDOWN: begin
                    if (state == ST_FALL) begin
                        if (at_end) begin
                            cnt_d = (one_shot || max_next == CNT_ZERO) ? CNT_ZERO : CNT_ONE;
                        end else begin
                            cnt_d = cnt_q - CNT_ONE;
                        end
                    end else if (at_top) begin
                        cnt_d = (max_act == CNT_ZERO) ? CNT_ZERO : max_act - CNT_ONE;
                    end else begin
                        cnt_d = cnt_q + CNT_ONE;
                    end
                end
                DIR_UP, DIR_UP_ALT: cnt_d = at_end ? CNT_ZERO : cnt_q + CNT_ONE;
                default:            cnt_d = at_end ? CNT_ZERO : cnt_q + CNT_ONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= CNT_ZERO;
            done_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            done_q <= advance && at_end;
        end
    end

    assign count      = cnt_q;
    assign cycle_done = done_q;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [1:0]       dir_mode,
    input  logic             one_shot,
    input  logic             preset,
    input  logic             run_start,
    input  logic             run_stop,
    input  logic             max_wr,
    input  logic [CNT_W-1:0] max_data,
    output logic             max_busy,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             cycle_done
);

    dir_mode_e        mode;
    seq_state_e       state;
    logic             advance;
    logic             boundary;
    logic             at_top;
    logic             at_end;
    logic [CNT_W-1:0] max_act;
    logic [CNT_W-1:0] max_next;

    assign mode     = dir_mode_e'(dir_mode);
    assign advance  = running && tick_en && !preset && !run_stop;
    assign boundary = advance && at_end;

    tick_timer_seq i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .one_shot  (one_shot),
        .run_start (run_start),
        .run_stop  (run_stop),
        .preset    (preset),
        .advance   (advance),
        .at_top    (at_top),
        .at_end    (at_end),
        .state     (state),
        .running   (running)
    );

    tick_timer_count #(.CNT_W(CNT_W)) i_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .state      (state),
        .one_shot   (one_shot),
        .preset     (preset),
        .advance    (advance),
        .max_act    (max_act),
        .max_next   (max_next),
        .count      (count),
        .at_top     (at_top),
        .at_end     (at_end),
        .cycle_done (cycle_done)
    );

    tick_timer_limit #(.CNT_W(CNT_W)) i_limit (
        .clk      (clk),
        .rst_n    (rst_n),
        .running  (running),
        .boundary (boundary),
        .wr_en    (max_wr),
        .wr_data  (max_data),
        .max_act  (max_act),
        .max_next (max_next),
        .busy     (max_busy)
    );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             preset,
    input logic             run_stop,
    input logic             max_wr,
    input logic [1:0]       dir_mode,
    input logic [CNT_W-1:0] count,
    input logic             running,
    input logic             max_busy,
    input logic [CNT_W-1:0] max_act
);

    // R2: a stopped counter without preset keeps its count
    assert_hold_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !preset) |=> $stable(count));

    // R10: the busy flag is low one edge after any stopped cycle
    assert_busy_clear_stopped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> !max_busy);

    // R9: busy only rises after a write made while running
    assert_busy_from_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(max_busy) |-> ($past(max_wr) && $past(running)));

    // R6: a self-stop (no stop strobe) leaves the count at zero
    assert_oneshot_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(running) && !$past(run_stop)) |-> (count == '0));

    // R7: preset lands the maximum in down direction, zero otherwise
    assert_preset_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(preset) |-> (count == (($past(dir_mode) == 2'b01) ? $past(max_act) : '0)));

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .preset   (preset),
    .run_stop (run_stop),
    .max_wr   (max_wr),
    .dir_mode (dir_mode),
    .count    (count),
    .running  (running),
    .max_busy (max_busy),
    .max_act  (max_act)
);

// File: tb/test_tick_timer.sv
module test_tick_timer;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_en = 1'b0;
    logic [1:0]       dir_mode = 2'b00;
    logic             one_shot = 1'b0;
    logic             preset = 1'b0;
    logic             run_start = 1'b0;
    logic             run_stop = 1'b0;
    logic             max_wr = 1'b0;
    logic [CNT_W-1:0] max_data = '0;
    logic             max_busy;
    logic [CNT_W-1:0] count;
    logic             running;
    logic             cycle_done;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_timer #(.CNT_W(CNT_W)) i_tick_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .dir_mode   (dir_mode),
        .one_shot   (one_shot),
        .preset     (preset),
        .run_start  (run_start),
        .run_stop   (run_stop),
        .max_wr     (max_wr),
        .max_data   (max_data),
        .max_busy   (max_busy),
        .count      (count),
        .running    (running),
        .cycle_done (cycle_done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_preset();
        preset = 1'b1; step(); preset = 1'b0;
    endtask

    task automatic do_start();
        run_start = 1'b1; step(); run_start = 1'b0;
    endtask

    task automatic do_stop();
        run_stop = 1'b1; step(); run_stop = 1'b0;
    endtask

    task automatic set_max(input int v);
        max_wr = 1'b1; max_data = CNT_W'(v); step(); max_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "count", int'(count), 0);
        chk("R1", "running", int'(running), 0);
        chk("R1", "busy", int'(max_busy), 0);
        chk("R1", "cycle_done", int'(cycle_done), 0);
        dir_mode = 2'b01;
        do_preset();
        chk("R1", "reset max via down preset", int'(count), 65535);
    endtask

    task automatic t_up_repeat();
        set_max(4);
        dir_mode = 2'b00; one_shot = 1'b0; tick_en = 1'b1;
        do_preset();
        chk("R7", "up preset", int'(count), 0);
        do_start();
        chk("R8", "start running", int'(running), 1);
        chk("R8", "no move on start", int'(count), 0);
        for (int k = 1; k <= 10; k++) begin
            step();
            chk("R3", "up count", int'(count), k % 5);
            chk("R3", "up done", int'(cycle_done), int'(k % 5 == 0));
        end
        begin
            int v;
            v = int'(count);
            do_stop();
            chk("R8", "stopped", int'(running), 0);
            chk("R8", "stop beats tick", int'(count), v);
            step(3);
            chk("R2", "hold when stopped", int'(count), v);
        end
    endtask

    task automatic t_up_alt();
        dir_mode = 2'b11; tick_en = 1'b1;
        do_preset(); do_start();
        for (int k = 1; k <= 5; k++) begin
            step();
            chk("R3", "alt up count", int'(count), k % 5);
        end
        do_stop();
    endtask

    task automatic t_down_repeat();
        dir_mode = 2'b01; one_shot = 1'b0; tick_en = 1'b1;
        do_preset();
        chk("R7", "down preset loads max", int'(count), 4);
        do_start();
        for (int k = 1; k <= 10; k++) begin
            step();
            chk("R4", "down count", int'(count), 4 - (k % 5));
            chk("R4", "down done", int'(cycle_done), int'(k % 5 == 0));
        end
        do_stop();
    endtask

    task automatic t_updown();
        int exp_v [6] = '{0, 1, 2, 3, 2, 1};
        set_max(3);
        dir_mode = 2'b10; one_shot = 1'b0; tick_en = 1'b1;
        do_preset(); do_start();
        for (int k = 1; k <= 13; k++) begin
            step();
            chk("R5", "updown count", int'(count), exp_v[k % 6]);
            chk("R5", "updown done", int'(cycle_done), int'((k % 6 == 1) && k > 1));
        end
        do_stop();
    endtask

    task automatic t_oneshot();
        set_max(2);
        one_shot = 1'b1; tick_en = 1'b1;
        // up
        dir_mode = 2'b00; do_preset(); do_start();
        step(); chk("R6", "os up 1", int'(count), 1);
        step(); chk("R6", "os up 2", int'(count), 2);
        step(); chk("R6", "os up end count", int'(count), 0);
        chk("R6", "os up done", int'(cycle_done), 1);
        chk("R6", "os up stopped", int'(running), 0);
        step(); chk("R6", "os up stays", int'(count), 0);
        // down
        dir_mode = 2'b01; do_preset(); do_start();
        step(); chk("R6", "os down 1", int'(count), 1);
        step(); chk("R6", "os down 0", int'(count), 0);
        chk("R6", "os down still running", int'(running), 1);
        step(); chk("R6", "os down no reload", int'(count), 0);
        chk("R6", "os down done", int'(cycle_done), 1);
        chk("R6", "os down stopped", int'(running), 0);
        // up/down
        dir_mode = 2'b10; do_preset(); do_start();
        step(4);
        chk("R6", "os updown at zero", int'(count), 0);
        chk("R6", "os updown running", int'(running), 1);
        step(); chk("R6", "os updown end", int'(count), 0);
        chk("R6", "os updown done", int'(cycle_done), 1);
        chk("R6", "os updown stopped", int'(running), 0);
        one_shot = 1'b0;
    endtask

    task automatic t_tick_gate_and_preset();
        set_max(10);
        dir_mode = 2'b00; tick_en = 1'b0;
        do_preset(); do_start();
        step(3);
        chk("R2", "no tick no move", int'(count), 0);
        tick_en = 1'b1; step(); tick_en = 1'b0;
        chk("R2", "one tick", int'(count), 1);
        step(2);
        chk("R2", "hold without tick", int'(count), 1);
        tick_en = 1'b1;
        do_preset();
        chk("R7", "preset beats tick", int'(count), 0);
        chk("R7", "preset keeps running", int'(running), 1);
        step();
        chk("R7", "resumes after preset", int'(count), 1);
        do_stop();
    endtask

    task automatic t_busy();
        set_max(4);
        dir_mode = 2'b00; tick_en = 1'b1;
        do_preset(); do_start();
        step();
        chk("R9", "pre-write count", int'(count), 1);
        max_wr = 1'b1; max_data = 16'd6;
        step();
        chk("R9", "busy after write", int'(max_busy), 1);
        chk("R9", "count k1", int'(count), 2);
        max_data = 16'd9;          // ignored: busy
        step();
        max_wr = 1'b0;
        chk("R9", "count k2", int'(count), 3);
        for (int k = 3; k <= 11; k++) begin
            step();
            chk("R9", "deferred count", int'(count), (k < 4) ? k + 1 : (k - 4) % 7);
            chk("R9", "busy", int'(max_busy), int'(k < 4));
        end
        chk("R9", "wrap at new max", int'(cycle_done), 1);
        do_stop();
    endtask

    task automatic t_stopped_write();
        set_max(2);
        chk("R10", "busy stays low", int'(max_busy), 0);
        dir_mode = 2'b00; tick_en = 1'b1;
        do_preset(); do_start();
        step(); chk("R10", "count 1", int'(count), 1);
        step(); chk("R10", "count 2", int'(count), 2);
        step(); chk("R10", "wrap at 2", int'(count), 0);
        chk("R10", "done at 2", int'(cycle_done), 1);
        do_stop();
    endtask

    initial begin
        step(2);
        rst_n = 1'b1;
        step();
        t_reset();
        t_up_repeat();
        t_up_alt();
        t_down_repeat();
        t_updown();
        t_oneshot();
        t_tick_gate_and_preset();
        t_busy();
        t_stopped_write();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule